// File: doc/BRIEF.md
# Shared-Bus Address Capture and Port Decoder

This block sits beside a processor that has one 8-bit bus for both addresses and data. A memory address is 14 bits wide, reaching 16K bytes of byte-wide memory, so the processor sends it as two bytes in two consecutive bus states. The block holds those bytes in an external address register and drives the full address to the memory. It also turns the cycle type carried in the top of the high byte into a memory read strobe, a memory write strobe, or a one-hot select for one of 8 input ports or 24 output ports.

A two-bit phase input says what the bus carries in each clock: idle (0), address low byte (1), address high byte (2) or transfer (3). The low byte is staged when it arrives. The full address, the cycle type and a valid flag all update together at the end of the high-byte state. They then stay constant until the next high-byte state. The strobes and selects are combinational. They are qualified by the transfer phase and by the captured cycle type.

In the high byte, bits 7:6 give the cycle type: 00 instruction fetch, 01 memory read, 10 port I/O, 11 memory write. Bits 5:0 give address bits 13:8. In a port I/O cycle, bits 4:0 of the high byte are the port number.

Top module: `bus_addr_latch`

## Requirements
- R1: While reset is asserted and after it is released, addr_o is 0 and mem_rd_o, mem_wr_o, in_sel_o and out_sel_o are all 0.
- R2: A byte on bus_i during phase 1 becomes addr_o[7:0]. It appears only once the next phase-2 state has been registered; a phase-1 state alone leaves addr_o unchanged.
- R3: A phase-2 byte places its bits 5:0 in addr_o[13:8]. Its bits 7:6 never appear in the address.
- R4: addr_o keeps its value in every clock whose phase is not 2.
- R5: During phase 3, mem_rd_o is 1 when the captured type is 00 (fetch) or 01 (read), and 0 otherwise.
- R6: During phase 3, mem_wr_o is 1 exactly when the captured type is 11 (write).
- R7: During phase 3 with type 10, a port number n in 0..7 sets only in_sel_o[n].
- R8: During phase 3 with type 10, a port number n in 8..31 sets only out_sel_o[n-8]. Bit 5 of the high byte does not affect the port number.
- R9: At most one of mem_rd_o, mem_wr_o and the 32 select lines is 1 at any time, and all of them are 0 outside phase 3.
- R10: After reset, phase 3 raises no strobe or select until a phase-2 state has been registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 8 | Shared address/data bus byte |
| phase_i | input | 2 | Bus phase: 0 idle, 1 low byte, 2 high byte, 3 transfer |
| addr_o | output | 14 | Latched memory address |
| mem_rd_o | output | 1 | Memory read strobe (fetch or read) |
| mem_wr_o | output | 1 | Memory write strobe |
| in_sel_o | output | 8 | One-hot input port select |
| out_sel_o | output | 24 | One-hot output port select |

## Verification
The hardest case to reach is a transfer phase that follows reset before any address has been captured. Here the cleared cycle type still decodes as a fetch, and only the valid flag prevents a read strobe. The bench drives phase 3 directly after reset and checks that all strobes stay low. It then drives a low byte, several idle clocks and the high byte, to show that the staged low byte survives the gap and that the address does not move early. It also checks port numbers 7 and 8, which sit on the boundary between input and output selects.

// File: rtl/bus_addr_pkg.sv
package bus_addr_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LO   = 2'd1,
        PH_HI   = 2'd2,
        PH_XFER = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        CY_FETCH = 2'd0,
        CY_READ  = 2'd1,
        CY_IO    = 2'd2,
        CY_WRITE = 2'd3
    } cyc_t;
endpackage

// File: rtl/addr_capture.sv
module addr_capture
    import bus_addr_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int ADDR_W = 14
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [BUS_W-1:0]  bus_i,
    input  phase_t            phase_i,
    output logic [ADDR_W-1:0] addr_o,
    output cyc_t              cyc_o,
    output logic              vld_o
);
    localparam int HI_W = ADDR_W - BUS_W;

    typedef struct packed {
        logic [BUS_W-1:0]  lo;
        logic [ADDR_W-1:0] addr;
        cyc_t              cyc;
        logic              vld;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (phase_i == PH_LO) begin
            st_d.lo = bus_i;
        end
        if (phase_i == PH_HI) begin
            st_d.addr = {bus_i[HI_W-1:0], st_q.lo};
            st_d.cyc  = cyc_t'(bus_i[BUS_W-1 -: 2]);
            st_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;
    assign cyc_o  = st_q.cyc;
    assign vld_o  = st_q.vld;

    AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_i != PH_HI) |=> $stable(addr_o)) else $error("addr moved"); // R4
    AST_HI_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_i == PH_HI) |=> (addr_o[ADDR_W-1:BUS_W] == $past(bus_i[HI_W-1:0])))
        else $error("high bits wrong"); // R3
    AST_LO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_i == PH_LO) ##1 (phase_i == PH_HI) |=> (addr_o[BUS_W-1:0] == $past(bus_i, 2)))
        else $error("low byte wrong"); // R2
endmodule

// File: rtl/port_decode.sv
module port_decode #(
    parameter int N_IN  = 8,
    parameter int N_OUT = 24,
    parameter int PN_W  = $clog2(N_IN + N_OUT)
) (
    input  logic             en_i,
    input  logic [PN_W-1:0]  port_i,
    output logic [N_IN-1:0]  in_sel_o,
    output logic [N_OUT-1:0] out_sel_o
);
    for (genvar i = 0; i < N_IN; i++) begin : g_in
        assign in_sel_o[i] = en_i && (int'(port_i) == i);
    end
    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        assign out_sel_o[j] = en_i && (int'(port_i) == j + N_IN);
    end
endmodule

// File: rtl/bus_addr_latch.sv
module bus_addr_latch
    import bus_addr_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int ADDR_W = 14,
    parameter int N_IN   = 8,
    parameter int N_OUT  = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [BUS_W-1:0]  bus_i,
    input  logic [1:0]        phase_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [N_IN-1:0]   in_sel_o,
    output logic [N_OUT-1:0]  out_sel_o
);
    localparam int PN_W = $clog2(N_IN + N_OUT);

    phase_t phase;
    cyc_t   cyc;
    logic   vld;
    logic   xfer;

    assign phase = phase_t'(phase_i);

    addr_capture #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) cap_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .bus_i   (bus_i),
        .phase_i (phase),
        .addr_o  (addr_o),
        .cyc_o   (cyc),
        .vld_o   (vld)
    );

    assign xfer     = (phase == PH_XFER) && vld;
    assign mem_rd_o = xfer && ((cyc == CY_FETCH) || (cyc == CY_READ));
    assign mem_wr_o = xfer && (cyc == CY_WRITE);

    port_decode #(.N_IN(N_IN), .N_OUT(N_OUT), .PN_W(PN_W)) dec_i (
        .en_i      (xfer && (cyc == CY_IO)),
        .port_i    (addr_o[BUS_W +: PN_W]),
        .in_sel_o  (in_sel_o),
        .out_sel_o (out_sel_o)
    );

    AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({mem_rd_o, mem_wr_o, in_sel_o, out_sel_o})) else $error("multi strobe"); // R9
    AST_QUIET_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase != PH_XFER) |-> !(mem_rd_o || mem_wr_o || (|in_sel_o) || (|out_sel_o)))
        else $error("strobe outside transfer"); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        !rst_ni |-> (addr_o == '0)) else $error("reset address"); // R1
endmodule

// File: tb/bus_addr_latch_tb.sv
module bus_addr_latch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;
    // each entry: {low byte, high byte}
    localparam logic [15:0] VEC [NV] = '{
        16'h343F, 16'hA552, 16'h00E0, 16'hFFFF, 16'h1180,
        16'h2287, 16'h3388, 16'h449F, 16'h55A3, 16'h6A40
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  bus = 0;
    logic [1:0]  phase = 0;
    logic [13:0] addr;
    logic        rd, wr;
    logic [7:0]  isel;
    logic [23:0] osel;
    int checks = 0;
    int fails = 0;
    logic [13:0] held;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_addr_latch dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_i(bus), .phase_i(phase),
        .addr_o(addr), .mem_rd_o(rd), .mem_wr_o(wr), .in_sel_o(isel), .out_sel_o(osel)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] ph, input logic [7:0] b);
        @(negedge clk);
        phase = ph;
        bus = b;
        #1;
    endtask

    task automatic quiet(input string req);
        chk(req, {rd, wr, isel, osel}, 64'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        drive(2'd0, 8'h00);
        chk("R1 addr", addr, 0);
        quiet("R1 strobes");
        @(negedge clk); rst_n = 1;
        // R10: transfer right after reset, before any address
        drive(2'd3, 8'h00);
        quiet("R10 unarmed transfer");
        chk("R1 addr after release", addr, 0);

        for (int i = 0; i < NV; i++) begin
            logic [7:0] lo, hi;
            logic [1:0] ty;
            logic [4:0] pn;
            lo = VEC[i][15:8];
            hi = VEC[i][7:0];
            ty = hi[7:6];
            pn = hi[4:0];
            drive(2'd1, lo);
            drive(2'd2, hi);
            quiet("R9 outside transfer");
            drive(2'd3, 8'h5A);
            chk("R2 R3 address", addr, {hi[5:0], lo});
            chk("R5 read strobe", rd, (ty == 2'b00) || (ty == 2'b01));
            chk("R6 write strobe", wr, ty == 2'b11);
            chk("R7 input select", isel, (ty == 2'b10 && pn < 8) ? (8'h1 << pn) : 8'h0);
            chk("R8 output select", osel, (ty == 2'b10 && pn >= 8) ? (24'h1 << (pn - 8)) : 24'h0);
            drive(2'd0, 8'hC3);
            quiet("R9 idle");
        end

        // R2/R4: low byte alone does not move the address; staged byte survives idles
        held = addr;
        drive(2'd1, 8'h77);
        drive(2'd0, 8'hEE);
        chk("R2 low byte not yet visible", addr, held);
        drive(2'd3, 8'h99);
        chk("R4 hold in transfer", addr, held);
        drive(2'd0, 8'h11);
        drive(2'd2, 8'hC9);
        drive(2'd0, 8'h00);
        chk("R2 staged low byte", addr, 14'h0977);
        chk("R3 type bits excluded", addr[13:8], 6'h09);
        drive(2'd3, 8'h00);
        chk("R6 write after gap", wr, 1'b1);

        // R1: reset in the middle of a transfer
        @(negedge clk); rst_n = 0; #1;
        chk("R1 mid reset addr", addr, 0);
        quiet("R1 mid reset strobes");
        @(negedge clk); rst_n = 1;
        drive(2'd3, 8'h00);
        quiet("R10 after second reset");

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule